// File: doc/BRIEF.md
# Wake-Session Flag and Timeout Controller

This block is the device-side session sequencer of a single-wire challenge/response device. It sits above the token codec. The codec hands it decoded bytes and three event strobes: a wake, a legal token and an illegal token. The block keeps track of whether the device is asleep, waiting for a flag, taking in a command block, parsing, busy executing, sending a reply, or parked in a paused state. Each byte that arrives while the device waits for a flag is read as an 8-bit flag. A command flag opens the receive path. A transmit flag starts a four-byte reply block towards the codec. A sleep flag returns the device to its reset state.

The controller checks each incoming command block for length and for checksum. It handles the pause command on its own, using a 4-bit address held in fuses, and passes every other command to an external executor through a start strobe. It then waits for that executor's result. Two timers can force the device to sleep. An inter-token timer restarts on every legal token. An absolute session timer starts at wake and cannot be restarted. When either timer forces sleep, the block raises a one-cycle sleep request so that the rest of the device can reset.

Top module: `wake_session_ctrl`

## Requirements
- R1: After reset the block is asleep: `busy` and `txValid` are low and `sleepReq` stays low. While asleep, every received byte (including 0x88) is ignored and only `wakeEvt` leaves the state.
- R2: A transmit flag (0x88) received after wake and before any command produces a reply block of four bytes on `txByte`: 0x04, status 0x11, then the CRC low byte and the CRC high byte. The CRC is CRC-16 with polynomial 0x8005 and initial value 0, with no final XOR, and the bits of each byte are taken LSB first. It is computed over the count byte and the status byte. Each further 0x88 returns the same block again.
- R3: A flag byte other than 0x77, 0x88 or 0xCC has no effect: nothing is sent and the held reply is unchanged.
- R4: A command block has the layout count, opcode, param1, two param2 bytes, data, CRC low, CRC high. The count covers the whole block. The block is a communication error if the count is below 7, if the count differs from the length the opcode requires (39 for opcode 0x08, 7 for any other opcode), or if the CRC over every byte before the CRC does not match. After the parse delay, such a block leaves status 0xFF and nothing is started.
- R5: A well-formed command other than pause pulses `cmdStart` with the opcode on `cmdOpcode` at the end of the parse delay. `busy` is high from the end of the block until `execDone`. Transmit flags are ignored while `busy` is high. When execution completes, the held status becomes `execByte`, or 0x0F if `execErr` is set.
- R6: A pause command (opcode 0x01) with param1 = 0x00 enters the pause state and sends no reply. In the pause state every byte and wake is ignored until the session timer forces sleep.
- R7: A pause command with a nonzero param1 pauses the device only if param1[3:0] equals `selFuse`. Otherwise it leaves status 0x0F and the device stays awake.
- R8: While waiting for a flag or receiving a command, the device goes to sleep after `TMO_CYC` cycles with no legal token, and `sleepReq` pulses for one cycle.
- R9: Every legal token restarts the inter-token timer, so a session with tokens spaced closer than `TMO_CYC` stays awake.
- R10: After an illegal token, no later token restarts the inter-token timer until the device sleeps.
- R11: The session timer forces sleep `WDOG_CYC` cycles after wake, whatever the activity.
- R12: A sleep flag (0xCC) sends the device to sleep at once. The next wake again reports status 0x11.
- R13: The inter-token timer does not run while `busy` is high, so execution longer than `TMO_CYC` does not cause sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wakeEvt | input | 1 | Wake token detected by the codec |
| tokenEvt | input | 1 | A legal token was received |
| illegalTok | input | 1 | An illegal token was received |
| rxValid | input | 1 | A decoded byte is present |
| rxData | input | 8 | Decoded byte |
| selFuse | input | 4 | Fuse bits that form the pause address |
| execDone | input | 1 | Executor finished the started command |
| execErr | input | 1 | Executor could not run the command |
| execByte | input | 8 | Executor result byte |
| txReady | input | 1 | Codec accepts the byte on `txByte` |
| txValid | output | 1 | A reply byte is offered |
| txByte | output | 8 | Reply byte |
| cmdStart | output | 1 | One-cycle start of a parsed command |
| cmdOpcode | output | 8 | Opcode of the received command |
| cmdParam | output | 8 | First parameter of the received command |
| busy | output | 1 | Parsing or executing |
| sleepReq | output | 1 | One-cycle pulse when the device is forced to sleep |

## Verification
Assertions check several properties on every cycle. A reply block always opens with the count byte 0x04. The sleep request lasts a single cycle. Nothing is sent in the cycle after a busy one. Execution and the pause state never end in sleep unless the session timer has expired. Parsing starts only after a complete block has been received. The bench scenarios are the only way to show the exact status values, the CRC bytes, the pause-address match, and where the timeouts fall in time. These scenarios measure how far the sleep pulse lies from wake or from the last legal token, and check that a reply read after wake is the wake status and not a result left over from an earlier session.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  localparam logic [7:0] FLAG_CMD   = 8'h77;
  localparam logic [7:0] FLAG_XMIT  = 8'h88;
  localparam logic [7:0] FLAG_SLEEP = 8'hCC;
  localparam logic [7:0] STAT_WOKE  = 8'h11;
  localparam logic [7:0] STAT_EXEC  = 8'h0F;
  localparam logic [7:0] STAT_COMM  = 8'hFF;
  localparam logic [7:0] OP_PAUSE   = 8'h01;
  localparam logic [7:0] OP_LONG    = 8'h08;
  localparam logic [7:0] LEN_SHORT  = 8'd7;
  localparam logic [7:0] LEN_LONG   = 8'd39;
  localparam logic [7:0] REPLY_LEN  = 8'd4;
  localparam logic [15:0] CRC_POLY  = 16'h8005;

  typedef enum logic [2:0] {
    S_SLEEP, S_IDLE, S_CMDRX, S_PARSE, S_BUSY, S_SEND, S_PAUSE
  } sessState_t;

  typedef enum logic [1:0] {R_WOKE, R_COMM, R_EXECERR, R_EXEC} respSel_t;

  typedef struct packed {
    logic     clrRx;
    logic     rxByte;
    logic     loadResp;
    respSel_t respSel;
    logic     clrSend;
    logic     advSend;
  } dpStb_t;

  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = d[i] ^ r[15];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  function automatic logic [7:0] needLen(input logic [7:0] op);
    return (op == OP_LONG) ? LEN_LONG : LEN_SHORT;
  endfunction
endpackage

// File: rtl/wsc_dp.sv
module wsc_dp
  import wsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  dpStb_t     stb,
  input  logic [7:0] rxData,
  input  logic [7:0] execByte,
  output logic       rxDone,
  output logic       commErr,
  output logic [7:0] opcode,
  output logic [7:0] param1,
  output logic [7:0] txByte,
  output logic       sendLast
);
  logic [7:0]  idx, cntReg, crcLoReg, crcHiReg, respReg;
  logic [15:0] crcAcc, respCrc;
  logic [1:0]  sendIdx;
  logic        isLast;

  assign isLast = stb.rxByte &&
                  ((idx == 8'd0 && rxData < LEN_SHORT) ||
                   (idx != 8'd0 && idx == cntReg - 8'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0; cntReg <= '0; opcode <= '0; param1 <= '0;
      crcLoReg <= '0; crcHiReg <= '0; crcAcc <= '0; rxDone <= 1'b0;
    end else begin
      rxDone <= isLast;
      if (stb.clrRx) begin
        idx <= '0; cntReg <= '0; opcode <= '0; param1 <= '0;
        crcLoReg <= '0; crcHiReg <= '0; crcAcc <= '0;
      end else if (stb.rxByte) begin
        idx <= idx + 8'd1;
        if (idx == 8'd0) cntReg <= rxData;
        if (idx == 8'd1) opcode <= rxData;
        if (idx == 8'd2) param1 <= rxData;
        if (idx == 8'd0 || idx < cntReg - 8'd2) crcAcc <= crcStep(crcAcc, rxData);
        if (idx != 8'd0 && idx == cntReg - 8'd2) crcLoReg <= rxData;
        if (idx != 8'd0 && idx == cntReg - 8'd1) crcHiReg <= rxData;
      end
    end
  end

  assign commErr = (cntReg < LEN_SHORT) || (cntReg != needLen(opcode)) ||
                   ({crcHiReg, crcLoReg} != crcAcc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      respReg <= STAT_WOKE;
      sendIdx <= '0;
    end else begin
      if (stb.loadResp) begin
        case (stb.respSel)
          R_WOKE:    respReg <= STAT_WOKE;
          R_COMM:    respReg <= STAT_COMM;
          R_EXECERR: respReg <= STAT_EXEC;
          default:   respReg <= execByte;
        endcase
      end
      if (stb.clrSend)      sendIdx <= '0;
      else if (stb.advSend) sendIdx <= sendIdx + 2'd1;
    end
  end

  assign respCrc  = crcStep(crcStep(16'h0000, REPLY_LEN), respReg);
  assign sendLast = (sendIdx == 2'd3);

  always_comb begin
    case (sendIdx)
      2'd0:    txByte = REPLY_LEN;
      2'd1:    txByte = respReg;
      2'd2:    txByte = respCrc[7:0];
      default: txByte = respCrc[15:8];
    endcase
  end

  // R2: the held status must not move while a reply is being sent
  a_r2_resp_held: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.advSend && !stb.loadResp) |=> (respReg == $past(respReg)));
endmodule

// File: rtl/wsc_ctrl.sv
module wsc_ctrl
  import wsc_pkg::*;
#(
  parameter int TMO_CYC   = 650000,
  parameter int WDOG_CYC  = 40000000,
  parameter int PARSE_CYC = 1000
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wakeEvt,
  input  logic       tokenEvt,
  input  logic       illegalTok,
  input  logic       byteValid,
  input  logic [7:0] byteData,
  input  logic [3:0] selFuse,
  input  logic       execDone,
  input  logic       execErr,
  input  logic       txReady,
  input  logic       rxDone,
  input  logic       commErr,
  input  logic [7:0] opcode,
  input  logic [7:0] param1,
  input  logic       sendLast,
  input  logic [7:0] txByte,
  output dpStb_t     stb,
  output logic       txValid,
  output logic       busy,
  output logic       cmdStart,
  output logic       sleepReq
);
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam int WW = $clog2(WDOG_CYC + 1);
  localparam int PW = $clog2(PARSE_CYC + 1);

  sessState_t    state, nxt;
  logic [TW-1:0] tmoCnt;
  logic [WW-1:0] wdCnt;
  logic [PW-1:0] parseCnt;
  logic          poison;
  logic tmoOn, restart, tmoExp, wdExp, sleepFlag, goSleep, parseEnd, selHit;

  assign tmoOn     = (state == S_IDLE) || (state == S_CMDRX);
  assign restart   = tokenEvt && !poison;
  assign tmoExp    = tmoOn && !restart && (tmoCnt == TW'(TMO_CYC - 1));
  assign wdExp     = (state != S_SLEEP) && (wdCnt == WW'(WDOG_CYC - 1));
  assign sleepFlag = (state == S_IDLE) && byteValid && (byteData == FLAG_SLEEP);
  assign goSleep   = (state != S_SLEEP) && (wdExp || tmoExp || sleepFlag);
  assign parseEnd  = (state == S_PARSE) && (parseCnt == PW'(PARSE_CYC - 1));
  assign selHit    = (param1 == 8'h00) || (param1[3:0] == selFuse);

  always_comb begin
    nxt = state;
    stb = '0;
    stb.respSel = R_WOKE;
    cmdStart = 1'b0;
    if (goSleep) begin
      nxt = S_SLEEP;
      stb.clrRx = 1'b1;
      stb.loadResp = 1'b1;
    end else begin
      case (state)
        S_SLEEP: if (wakeEvt) begin
          nxt = S_IDLE;
          stb.clrRx = 1'b1;
          stb.loadResp = 1'b1;
        end
        S_IDLE: if (byteValid) begin
          if (byteData == FLAG_CMD) begin
            nxt = S_CMDRX;
            stb.clrRx = 1'b1;
          end else if (byteData == FLAG_XMIT) begin
            nxt = S_SEND;
            stb.clrSend = 1'b1;
          end
        end
        S_CMDRX: begin
          if (rxDone) nxt = S_PARSE;
          else if (byteValid) stb.rxByte = 1'b1;
        end
        S_PARSE: if (parseEnd) begin
          if (commErr) begin
            nxt = S_IDLE;
            stb.loadResp = 1'b1;
            stb.respSel = R_COMM;
          end else if (opcode == OP_PAUSE) begin
            if (selHit) nxt = S_PAUSE;
            else begin
              nxt = S_IDLE;
              stb.loadResp = 1'b1;
              stb.respSel = R_EXECERR;
            end
          end else begin
            nxt = S_BUSY;
            cmdStart = 1'b1;
          end
        end
        S_BUSY: if (execDone) begin
          nxt = S_IDLE;
          stb.loadResp = 1'b1;
          stb.respSel = execErr ? R_EXECERR : R_EXEC;
        end
        S_SEND: if (txReady) begin
          stb.advSend = 1'b1;
          if (sendLast) nxt = S_IDLE;
        end
        S_PAUSE: nxt = S_PAUSE;
        default: nxt = S_SLEEP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_SLEEP; tmoCnt <= '0; wdCnt <= '0; parseCnt <= '0;
      poison <= 1'b0; sleepReq <= 1'b0;
    end else begin
      state    <= nxt;
      sleepReq <= goSleep;
      parseCnt <= (state == S_PARSE) ? parseCnt + PW'(1) : '0;
      tmoCnt   <= (!tmoOn || restart) ? '0 : tmoCnt + TW'(1);
      wdCnt    <= (state == S_SLEEP) ? '0 : wdCnt + WW'(1);
      if (state == S_SLEEP) poison <= 1'b0;
      else if (illegalTok)  poison <= 1'b1;
    end
  end

  assign txValid = (state == S_SEND);
  assign busy    = (state == S_PARSE) || (state == S_BUSY);

  // R2: a reply always opens with the count byte
  a_r2_count_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txValid) |-> (txByte == REPLY_LEN));
  // R8: the sleep request is a single-cycle pulse
  a_r8_sleep_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sleepReq |=> !sleepReq);
  // R5: no reply can follow a busy cycle
  a_r5_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !txValid);
  // R13: execution never ends in sleep unless the session timer fired
  a_r13_busy_no_tmo: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BUSY && !wdExp) |=> (state != S_SLEEP));
  // R6: the pause state holds until the session timer fires
  a_r6_pause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PAUSE && !wdExp) |=> (state == S_PAUSE));
  // R1: only a wake leaves sleep
  a_r1_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SLEEP && !wakeEvt) |=> (state == S_SLEEP));
  // R4: parsing begins only after a complete block
  a_r4_parse_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CMDRX && !rxDone) |=> (state != S_PARSE));
endmodule

// File: rtl/wake_session_ctrl.sv
module wake_session_ctrl
  import wsc_pkg::*;
#(
  parameter int TMO_CYC   = 650000,
  parameter int WDOG_CYC  = 40000000,
  parameter int PARSE_CYC = 1000
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wakeEvt,
  input  logic       tokenEvt,
  input  logic       illegalTok,
  input  logic       rxValid,
  input  logic [7:0] rxData,
  input  logic [3:0] selFuse,
  input  logic       execDone,
  input  logic       execErr,
  input  logic [7:0] execByte,
  input  logic       txReady,
  output logic       txValid,
  output logic [7:0] txByte,
  output logic       cmdStart,
  output logic [7:0] cmdOpcode,
  output logic [7:0] cmdParam,
  output logic       busy,
  output logic       sleepReq
);
  dpStb_t stb;
  logic   rxDone, commErr, sendLast;

  wsc_ctrl #(.TMO_CYC(TMO_CYC), .WDOG_CYC(WDOG_CYC), .PARSE_CYC(PARSE_CYC)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .wakeEvt(wakeEvt), .tokenEvt(tokenEvt),
    .illegalTok(illegalTok), .byteValid(rxValid), .byteData(rxData),
    .selFuse(selFuse), .execDone(execDone), .execErr(execErr), .txReady(txReady),
    .rxDone(rxDone), .commErr(commErr), .opcode(cmdOpcode), .param1(cmdParam),
    .sendLast(sendLast), .txByte(txByte), .stb(stb), .txValid(txValid),
    .busy(busy), .cmdStart(cmdStart), .sleepReq(sleepReq)
  );

  wsc_dp i_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .rxData(rxData), .execByte(execByte),
    .rxDone(rxDone), .commErr(commErr), .opcode(cmdOpcode), .param1(cmdParam),
    .txByte(txByte), .sendLast(sendLast)
  );
endmodule

// File: tb/test_wake_session_ctrl.sv
`timescale 1ns/1ps
module test_wake_session_ctrl;
  localparam int TMO = 200;
  localparam int WDOG = 3000;
  localparam int PARSE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wakeEvt = 0, tokenEvt = 0, illegalTok = 0, rxValid = 0, txReady = 1;
  logic [7:0] rxData = 0;
  logic [3:0] selFuse = 4'hA;
  logic execDone = 0, execErr = 0;
  logic [7:0] execByte = 0;
  logic txValid, cmdStart, busy, sleepReq;
  logic [7:0] txByte, cmdOpcode, cmdParam;

  always #2 clk = ~clk;

  wake_session_ctrl #(.TMO_CYC(TMO), .WDOG_CYC(WDOG), .PARSE_CYC(PARSE)) i_wake_session_ctrl (
    .clk(clk), .rst_n(rst_n), .wakeEvt(wakeEvt), .tokenEvt(tokenEvt),
    .illegalTok(illegalTok), .rxValid(rxValid), .rxData(rxData), .selFuse(selFuse),
    .execDone(execDone), .execErr(execErr), .execByte(execByte), .txReady(txReady),
    .txValid(txValid), .txByte(txByte), .cmdStart(cmdStart), .cmdOpcode(cmdOpcode),
    .cmdParam(cmdParam), .busy(busy), .sleepReq(sleepReq)
  );

  int nChk = 0, nFail = 0, cyc = 0;
  int sleepCnt = 0, lastSleepCyc = 0, txSeen = 0;
  int startCnt = 0, pend = 0, execDelay = 5;
  logic [7:0] lastOp = 0, execVal = 8'h5A;
  logic execErrVal = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && sleepReq) begin sleepCnt++; lastSleepCyc = cyc; end
    if (rst_n && txValid) txSeen++;
    execDone = 0;
    if (cmdStart) begin
      startCnt++; lastOp = cmdOpcode; pend = execDelay;
    end else if (pend > 0) begin
      if (pend == 1) begin execDone = 1; execByte = execVal; execErr = execErrVal; end
      pend--;
    end
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] refCrc(input logic [7:0] f[64], input int n);
    logic [15:0] c;
    logic top;
    c = 16'h0000;
    for (int j = 0; j < n; j++)
      for (int k = 0; k < 8; k++) begin
        top = c[15];
        c = c << 1;
        if (top ^ f[j][k]) c = c ^ 16'h8005;
      end
    return c;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b);
    rxValid = 1; rxData = b; tokenEvt = 1;
    @(negedge clk);
    rxValid = 0; tokenEvt = 0;
    @(negedge clk);
  endtask

  task automatic wake(output int at);
    at = cyc; wakeEvt = 1;
    @(negedge clk);
    wakeEvt = 0;
    idle(2);
  endtask

  task automatic xmit(output logic [7:0] r0, output logic [7:0] r1,
                      output logic [7:0] r2, output logic [7:0] r3, output int n);
    logic [7:0] b[4];
    for (int k = 0; k < 4; k++) b[k] = 8'h00;
    n = 0;
    rxValid = 1; rxData = 8'h88; tokenEvt = 1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      rxValid = 0; tokenEvt = 0;
      if (txValid && n < 4) begin b[n] = txByte; n++; end
    end
    r0 = b[0]; r1 = b[1]; r2 = b[2]; r3 = b[3];
  endtask

  task automatic expectResp(input string req, input logic [7:0] st);
    logic [7:0] r0, r1, r2, r3;
    logic [7:0] f[64];
    logic [15:0] c;
    int n;
    for (int k = 0; k < 64; k++) f[k] = 8'h00;
    f[0] = 8'h04; f[1] = st;
    c = refCrc(f, 2);
    xmit(r0, r1, r2, r3, n);
    chk({req, " reply length"}, n == 4, n, 4);
    chk({req, " count byte"}, r0 == 8'h04, r0, 8'h04);
    chk({req, " status"}, r1 == st, r1, st);
    chk({req, " crc"}, {r3, r2} == c, {r3, r2}, c);
  endtask

  task automatic expectNone(input string req);
    logic [7:0] r0, r1, r2, r3;
    int n;
    xmit(r0, r1, r2, r3, n);
    chk({req, " no reply"}, n == 0, n, 0);
  endtask

  task automatic sendCmd(input logic [7:0] op, input logic [7:0] p1, input int nData,
                         input bit badCrc, input int cntOverride);
    logic [7:0] f[64];
    logic [15:0] c;
    int cnt;
    for (int k = 0; k < 64; k++) f[k] = 8'h00;
    cnt = (cntOverride > 0) ? cntOverride : 7 + nData;
    f[0] = 8'(cnt); f[1] = op; f[2] = p1;
    for (int k = 0; k < nData; k++) f[5 + k] = 8'(k * 3 + 1);
    sendByte(8'h77);
    if (cnt < 7) sendByte(f[0]);
    else begin
      c = refCrc(f, cnt - 2);
      if (badCrc) c = c ^ 16'h0100;
      f[cnt - 2] = c[7:0]; f[cnt - 1] = c[15:8];
      for (int k = 0; k < cnt; k++) sendByte(f[k]);
    end
    idle(PARSE + 4);
  endtask

  task automatic goSleepFlag();
    sendByte(8'hCC);
    idle(3);
  endtask

  task automatic t_reset();
    chk("R1 busy at reset", busy == 0, busy, 0);
    chk("R1 txValid at reset", txValid == 0, txValid, 0);
    sendByte(8'h77);
    expectNone("R1 asleep");
    chk("R1 no sleep pulse", sleepCnt == 0, sleepCnt, 0);
  endtask

  task automatic t_wake();
    int w;
    wake(w);
    expectResp("R2 first read", 8'h11);
    expectResp("R2 reread", 8'h11);
    goSleepFlag();
  endtask

  task automatic t_reserved();
    int w, s0;
    wake(w);
    s0 = txSeen;
    sendByte(8'h00); sendByte(8'h55); sendByte(8'hFF); sendByte(8'h76);
    idle(3);
    chk("R3 nothing sent", txSeen == s0, txSeen, s0);
    chk("R3 not busy", busy == 0, busy, 0);
    expectResp("R3 state kept", 8'h11);
    goSleepFlag();
  endtask

  task automatic t_commErr();
    int w, st0;
    wake(w);
    st0 = startCnt;
    sendCmd(8'h02, 8'h00, 0, 1, 0);
    expectResp("R4 bad crc", 8'hFF);
    sendCmd(8'h02, 8'h00, 2, 0, 0);
    expectResp("R4 length mismatch", 8'hFF);
    sendCmd(8'h02, 8'h00, 0, 0, 3);
    expectResp("R4 short count", 8'hFF);
    chk("R4 nothing started", startCnt == st0, startCnt, st0);
    goSleepFlag();
  endtask

  task automatic t_exec();
    int w, st0, sl0;
    execDelay = TMO + 200; execVal = 8'h5A; execErrVal = 0;
    wake(w);
    st0 = startCnt; sl0 = sleepCnt;
    sendCmd(8'h02, 8'h33, 0, 0, 0);
    chk("R5 started", startCnt == st0 + 1, startCnt, st0 + 1);
    chk("R5 opcode", lastOp == 8'h02, lastOp, 8'h02);
    chk("R5 busy", busy == 1, busy, 1);
    expectNone("R5 transmit while busy");
    idle(TMO + 220);
    chk("R13 no timeout while busy", sleepCnt == sl0, sleepCnt, sl0);
    chk("R5 busy cleared", busy == 0, busy, 0);
    expectResp("R5 result", 8'h5A);
    execDelay = 5; execErrVal = 1;
    sendCmd(8'h08, 8'h00, 32, 0, 0);
    idle(10);
    chk("R5 long opcode started", lastOp == 8'h08, lastOp, 8'h08);
    expectResp("R5 exec error", 8'h0F);
    execErrVal = 0;
    goSleepFlag();
  endtask

  task automatic t_pause0();
    int w, sl0, st0;
    wake(w);
    sl0 = sleepCnt; st0 = startCnt;
    sendCmd(8'h01, 8'h00, 0, 0, 0);
    chk("R6 not started", startCnt == st0, startCnt, st0);
    chk("R6 not busy", busy == 0, busy, 0);
    expectNone("R6 paused");
    while (cyc < w + WDOG + 10) @(negedge clk);
    chk("R6 one sleep", sleepCnt == sl0 + 1, sleepCnt, sl0 + 1);
    chk("R6 sleep at session end", (lastSleepCyc >= w + WDOG - 1) && (lastSleepCyc <= w + WDOG + 3),
        lastSleepCyc - w, WDOG + 1);
  endtask

  task automatic t_pauseSel();
    int w, sl0;
    wake(w);
    sl0 = sleepCnt;
    sendCmd(8'h01, 8'h35, 0, 0, 0);
    expectResp("R7 selector mismatch", 8'h0F);
    sendCmd(8'h01, 8'hFA, 0, 0, 0);
    expectNone("R7 selector match");
    while (cyc < w + WDOG + 10) @(negedge clk);
    chk("R7 slept once", sleepCnt == sl0 + 1, sleepCnt, sl0 + 1);
  endtask

  task automatic t_timeout();
    int w, sl0;
    wake(w);
    sl0 = sleepCnt;
    while (cyc < w + TMO + 10) @(negedge clk);
    chk("R8 slept", sleepCnt == sl0 + 1, sleepCnt, sl0 + 1);
    chk("R8 timeout cycle", (lastSleepCyc >= w + TMO - 1) && (lastSleepCyc <= w + TMO + 3),
        lastSleepCyc - w, TMO + 1);
    expectNone("R8 asleep after timeout");
  endtask

  task automatic t_restart();
    int w, sl0;
    wake(w);
    sl0 = sleepCnt;
    for (int k = 0; k < 6; k++) begin sendByte(8'h00); idle(100); end
    chk("R9 still awake", sleepCnt == sl0, sleepCnt, sl0);
    expectResp("R9 reply", 8'h11);
    goSleepFlag();
  endtask

  task automatic t_illegal();
    int w, sl0, ill;
    wake(w);
    sl0 = sleepCnt;
    sendByte(8'h00);
    ill = cyc; illegalTok = 1;
    @(negedge clk);
    illegalTok = 0;
    for (int k = 0; k < 8; k++) begin sendByte(8'h00); idle(48); end
    chk("R10 slept", sleepCnt == sl0 + 1, sleepCnt, sl0 + 1);
    chk("R10 sleep time", (lastSleepCyc >= ill + TMO - 5) && (lastSleepCyc <= ill + TMO + 5),
        lastSleepCyc - ill, TMO);
  endtask

  task automatic t_watchdog();
    int w, sl0;
    wake(w);
    sl0 = sleepCnt;
    while (cyc < w + WDOG + 40) begin sendByte(8'h00); idle(48); end
    chk("R11 slept once", sleepCnt == sl0 + 1, sleepCnt, sl0 + 1);
    chk("R11 session end", (lastSleepCyc >= w + WDOG - 1) && (lastSleepCyc <= w + WDOG + 3),
        lastSleepCyc - w, WDOG + 1);
  endtask

  task automatic t_sleepFlag();
    int w, sl0;
    execDelay = 5; execVal = 8'h5A; execErrVal = 0;
    wake(w);
    sendCmd(8'h02, 8'h00, 0, 0, 0);
    idle(10);
    expectResp("R12 before sleep", 8'h5A);
    sl0 = sleepCnt;
    sendByte(8'hCC);
    idle(1);
    chk("R12 immediate sleep", sleepCnt == sl0 + 1, sleepCnt, sl0 + 1);
    expectNone("R12 asleep");
    wake(w);
    expectResp("R12 fresh wake", 8'h11);
    goSleepFlag();
  endtask

  initial begin
    idle(4);
    rst_n = 1;
    idle(3);
    t_reset();
    t_wake();
    t_reserved();
    t_commErr();
    t_exec();
    t_pause0();
    t_pauseSel();
    t_timeout();
    t_restart();
    t_illegal();
    t_watchdog();
    t_sleepFlag();
    idle(5);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 100000, 0);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule